// File: doc/BRIEF.md
# Constant-Current Chopper Phase Gate for a Two-Winding Unipolar Stepper

This block sits between a step sequencer and the four low-side power switches of a unipolar stepping motor. Each of the two windings has a primary and a complementary switch. The sequencer gives, for each winding, a side select (which switch should conduct) and a current-level code. The analog side feeds back one over-current comparator flag per winding. The block turns the selected switch on at the start of every chop period. It cuts the switch off when the comparator trips, and keeps it off until the next period starts.

The chop period is a fixed number of system clocks set by a parameter. For example, 2660 clocks at 125 MHz gives about 47 kHz, which must stay between 37 and 57 kHz. Each turn-on is followed by a hold interval. During the hold, comparator trips are ignored. This covers both blanking of the switching spike and the minimum on-time, so a small winding current flows even at the lowest nonzero level. A level code of zero keeps the winding dark. When the side select of a winding changes, both of its switches stay off for a dead interval before the new switch conducts. The default dead interval of 469 clocks is about 3.75 µs at 125 MHz.

The drive-enable input blanks all four outputs at once and freezes the whole controller: the oscillator, the hold and dead timers, and the recorded sides. The controller then resumes exactly where it stopped.

Top module: `chop_phase_ctrl`

## Requirements
- R1: With drive enabled, a nonzero level and no side change pending, each winding's selected switch turns on in the first clock after reset release and then every CHOP_DIV enabled clocks after that.
- R2: A comparator trip passes through a two-flop synchroniser. If the hold interval has elapsed, the switch goes off on the third rising edge after the trip input goes high. The switch stays off until the next period start, even after the trip clears.
- R3: After any turn-on, the switch stays on for at least HOLD = max(MIN_ON_CYC, BLANK_CYC) enabled clocks, whatever the comparator does.
- R4: When a winding's side select differs from its recorded side, both of its switches are off for exactly DEAD_CYC enabled clocks. The new switch then turns on at once if the level is nonzero, without waiting for a period start.
- R5: A level code of zero turns the winding off at the next edge, with no hold applied. A later nonzero level takes effect at the next period start.
- R6: While drive_en is low, all four outputs are 0 in the same cycle. The oscillator, the timers and the recorded sides do not change, and side selects are not looked at.
- R7: A synchronous active-low reset turns all outputs off, restarts the oscillator at count zero, cancels any pending dead interval and sets both recorded sides to primary.
- R8: A side select of 0 chooses the primary switch (sw_a_p or sw_b_p) and 1 chooses the complementary switch (sw_a_n or sw_b_n). The two switches of one winding never rise within DEAD_CYC clocks of the other having been on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drive_en | input | 1 | Drive enable; low blanks outputs and freezes state |
| pol_a | input | 1 | Winding A side select (0 primary, 1 complementary) |
| pol_b | input | 1 | Winding B side select (0 primary, 1 complementary) |
| lvl_a | input | LVL_W | Winding A current-level code, zero means off |
| lvl_b | input | LVL_W | Winding B current-level code, zero means off |
| trip_a | input | 1 | Winding A over-current comparator, asynchronous |
| trip_b | input | 1 | Winding B over-current comparator, asynchronous |
| sw_a_p | output | 1 | Winding A primary switch enable |
| sw_a_n | output | 1 | Winding A complementary switch enable |
| sw_b_p | output | 1 | Winding B primary switch enable |
| sw_b_n | output | 1 | Winding B complementary switch enable |

## Verification
Two collisions are provoked on purpose. In the first, a comparator trip is raised in the clock right after a turn-on, so the synchronised trip arrives while the hold interval is still running. The switch must stay on for the full hold and then drop on the first edge that is allowed. In the second, drive is disabled one clock after a period start and the comparators are then tripped. The next turn-on must come a full period of enabled clocks later, not a period of wall clocks. A dead interval that is cut short by reset checks that the cancel takes priority over the pending switch change.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic {
        SIDE_PRI = 1'b0,
        SIDE_CMP = 1'b1
    } side_e;

    localparam int unsigned NUM_WIND = 2;

    function automatic int unsigned imax(input int unsigned x, input int unsigned y);
        return (x > y) ? x : y;
    endfunction

endpackage

// File: rtl/chop_osc.sv
module chop_osc #(
    parameter int unsigned DIV = 2660
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic cyc_start
);
    localparam int unsigned DIV_EFF = (DIV < 2) ? 2 : DIV;
    localparam int unsigned CW      = $clog2(DIV_EFF);
    localparam logic [CW-1:0] LAST  = CW'(DIV_EFF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } osc_t;

    osc_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (run) begin
            s_d.cnt = (s_q.cnt == LAST) ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cyc_start = run && (s_q.cnt == '0);

endmodule

// File: rtl/trip_sync.sv
module trip_sync #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] synced
);
    typedef struct packed {
        logic [N-1:0] st1;
        logic [N-1:0] st2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.st1 = raw;
        s_d.st2 = s_q.st1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign synced = s_q.st2;

endmodule

// File: rtl/wind_ctrl.sv
module wind_ctrl
    import chop_pkg::*;
#(
    parameter int unsigned MIN_ON_CYC = 106,
    parameter int unsigned BLANK_CYC  = 32,
    parameter int unsigned DEAD_CYC   = 469,
    parameter int unsigned LVL_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cyc_start,
    input  logic             pol,
    input  logic [LVL_W-1:0] lvl,
    input  logic             trip_s,
    output logic             drv_p,
    output logic             drv_n
);
    localparam int unsigned HOLD     = imax(imax(MIN_ON_CYC, BLANK_CYC), 1);
    localparam int unsigned DEAD_EFF = imax(DEAD_CYC, 1);
    localparam int unsigned AW       = $clog2(HOLD + 1);
    localparam int unsigned DW       = $clog2(DEAD_EFF + 1);

    typedef struct packed {
        side_e          side;
        logic           on;
        logic [DW-1:0]  dead;
        logic [AW-1:0]  age;
    } wind_t;

    wind_t s_d, s_q;
    logic  lvl_nz;
    side_e want;

    assign lvl_nz = |lvl;
    assign want   = side_e'(pol);

    always_comb begin
        s_d = s_q;
        if (run) begin
            if (s_q.on && (s_q.age != AW'(HOLD))) begin
                s_d.age = s_q.age + 1'b1;
            end
            if (s_q.dead != '0) begin
                s_d.dead = s_q.dead - 1'b1;
                s_d.on   = 1'b0;
                if (s_q.dead == DW'(1)) begin
                    s_d.side = want;
                    s_d.on   = lvl_nz;
                    s_d.age  = '0;
                end
            end else if (want != s_q.side) begin
                s_d.dead = DW'(DEAD_EFF);
                s_d.on   = 1'b0;
            end else if (!lvl_nz) begin
                s_d.on = 1'b0;
            end else if (cyc_start) begin
                s_d.on  = 1'b1;
                s_d.age = '0;
            end else if (s_q.on && trip_s && (s_q.age >= AW'(HOLD - 1))) begin
                s_d.on = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.side <= SIDE_PRI;
        end else begin
            s_q <= s_d;
        end
    end

    assign drv_p = s_q.on && (s_q.side == SIDE_PRI);
    assign drv_n = s_q.on && (s_q.side == SIDE_CMP);

endmodule

// File: rtl/chop_phase_ctrl.sv
module chop_phase_ctrl
    import chop_pkg::*;
#(
    parameter int unsigned CHOP_DIV   = 2660,
    parameter int unsigned MIN_ON_CYC = 106,
    parameter int unsigned BLANK_CYC  = 32,
    parameter int unsigned DEAD_CYC   = 469,
    parameter int unsigned LVL_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drive_en,
    input  logic             pol_a,
    input  logic             pol_b,
    input  logic [LVL_W-1:0] lvl_a,
    input  logic [LVL_W-1:0] lvl_b,
    input  logic             trip_a,
    input  logic             trip_b,
    output logic             sw_a_p,
    output logic             sw_a_n,
    output logic             sw_b_p,
    output logic             sw_b_n
);
    logic                            cyc_start;
    logic [NUM_WIND-1:0]             pol_w;
    logic [NUM_WIND-1:0][LVL_W-1:0]  lvl_w;
    logic [NUM_WIND-1:0]             trip_raw;
    logic [NUM_WIND-1:0]             trip_s;
    logic [NUM_WIND-1:0]             drv_p;
    logic [NUM_WIND-1:0]             drv_n;

    assign pol_w    = {pol_b, pol_a};
    assign lvl_w    = {lvl_b, lvl_a};
    assign trip_raw = {trip_b, trip_a};

    chop_osc #(
        .DIV (CHOP_DIV)
    ) osc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (drive_en),
        .cyc_start (cyc_start)
    );

    trip_sync #(
        .N (NUM_WIND)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (trip_raw),
        .synced (trip_s)
    );

    for (genvar w = 0; w < NUM_WIND; w++) begin : g_wind
        wind_ctrl #(
            .MIN_ON_CYC (MIN_ON_CYC),
            .BLANK_CYC  (BLANK_CYC),
            .DEAD_CYC   (DEAD_CYC),
            .LVL_W      (LVL_W)
        ) wind_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (drive_en),
            .cyc_start (cyc_start),
            .pol       (pol_w[w]),
            .lvl       (lvl_w[w]),
            .trip_s    (trip_s[w]),
            .drv_p     (drv_p[w]),
            .drv_n     (drv_n[w])
        );
    end

    assign sw_a_p = drive_en && drv_p[0];
    assign sw_a_n = drive_en && drv_n[0];
    assign sw_b_p = drive_en && drv_p[1];
    assign sw_b_n = drive_en && drv_n[1];

endmodule

// File: rtl/chop_phase_ctrl_chk.sv
module chop_phase_ctrl_chk
    import chop_pkg::*;
#(
    parameter int unsigned CHOP_DIV   = 2660,
    parameter int unsigned MIN_ON_CYC = 106,
    parameter int unsigned BLANK_CYC  = 32,
    parameter int unsigned DEAD_CYC   = 469,
    parameter int unsigned LVL_W      = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             drive_en,
    input logic             pol_a,
    input logic             pol_b,
    input logic [LVL_W-1:0] lvl_a,
    input logic [LVL_W-1:0] lvl_b,
    input logic             sw_a_p,
    input logic             sw_a_n,
    input logic             sw_b_p,
    input logic             sw_b_n
);
    localparam int unsigned HOLD     = imax(imax(MIN_ON_CYC, BLANK_CYC), 1);
    localparam int unsigned DEAD_EFF = imax(DEAD_CYC, 1);
    localparam int unsigned AW       = $clog2(HOLD + 1);
    localparam int unsigned DW       = $clog2(DEAD_EFF + 1);

    logic [3:0]          sw;
    logic [1:0]          on_w;
    logic [1:0]          pol_v;
    logic [1:0]          lvl_nz_v;
    logic [DW-1:0]       off_q [4];
    logic [AW-1:0]       age_q [2];

    assign sw       = {sw_b_n, sw_b_p, sw_a_n, sw_a_p};
    assign on_w     = {sw_b_p | sw_b_n, sw_a_p | sw_a_n};
    assign pol_v    = {pol_b, pol_a};
    assign lvl_nz_v = {|lvl_b, |lvl_a};

    always_ff @(posedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (!rst_n || sw[i])                  off_q[i] <= (!rst_n) ? DW'(DEAD_EFF) : '0;
            else if (off_q[i] != DW'(DEAD_EFF))   off_q[i] <= off_q[i] + 1'b1;
        end
        for (int w = 0; w < 2; w++) begin
            if (!rst_n)                           age_q[w] <= '0;
            else if (drive_en && !on_w[w])        age_q[w] <= '0;
            else if (drive_en && age_q[w] != AW'(HOLD)) age_q[w] <= age_q[w] + 1'b1;
        end
    end

    for (genvar i = 0; i < 4; i++) begin : g_gap
        // R4 / R8: a switch rises only after its partner has been off DEAD_CYC clocks
        p_dead_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sw[i]) |-> (off_q[i ^ 1] >= DW'(DEAD_EFF)));
    end

    for (genvar w = 0; w < 2; w++) begin : g_wind
        p_min_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (drive_en && on_w[w] && (age_q[w] < AW'(HOLD - 1)) && lvl_nz_v[w]
             && (pol_v[w] == sw[2*w+1])) |=> (on_w[w] || !drive_en));

        p_lvl_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (drive_en && !lvl_nz_v[w]) |=> !on_w[w]);
    end

    p_blank_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |-> (sw == 4'b0000));

    p_reset_off_r7: assert property (@(posedge clk)
        !rst_n |=> (sw == 4'b0000));

endmodule

bind chop_phase_ctrl chop_phase_ctrl_chk #(
    .CHOP_DIV   (CHOP_DIV),
    .MIN_ON_CYC (MIN_ON_CYC),
    .BLANK_CYC  (BLANK_CYC),
    .DEAD_CYC   (DEAD_CYC),
    .LVL_W      (LVL_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .drive_en (drive_en),
    .pol_a    (pol_a),
    .pol_b    (pol_b),
    .lvl_a    (lvl_a),
    .lvl_b    (lvl_b),
    .sw_a_p   (sw_a_p),
    .sw_a_n   (sw_a_n),
    .sw_b_p   (sw_b_p),
    .sw_b_n   (sw_b_n)
);

// File: tb/chop_phase_ctrl_tb_top.sv
module chop_phase_ctrl_tb_top;

    localparam int unsigned PER  = 20;
    localparam int unsigned MINO = 4;
    localparam int unsigned BLNK = 2;
    localparam int unsigned DEAD = 6;
    localparam int unsigned LW   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drive_en = 1'b1;
    logic pol_a = 1'b0, pol_b = 1'b0;
    logic [LW-1:0] lvl_a = 4'd5, lvl_b = 4'd0;
    logic trip_a = 1'b0, trip_b = 1'b0;
    logic sw_a_p, sw_a_n, sw_b_p, sw_b_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    chop_phase_ctrl #(
        .CHOP_DIV (PER), .MIN_ON_CYC (MINO), .BLANK_CYC (BLNK),
        .DEAD_CYC (DEAD), .LVL_W (LW)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .drive_en (drive_en),
        .pol_a (pol_a), .pol_b (pol_b), .lvl_a (lvl_a), .lvl_b (lvl_b),
        .trip_a (trip_a), .trip_b (trip_b),
        .sw_a_p (sw_a_p), .sw_a_n (sw_a_n), .sw_b_p (sw_b_p), .sw_b_n (sw_b_n)
    );

    typedef struct packed {
        logic       en;
        logic       pa;
        logic       pb;
        logic [3:0] la;
        logic [3:0] lb;
        logic       ta;
        logic       tb;
        logic [7:0] wt;
        logic [3:0] exp;   // {sw_a_p, sw_a_n, sw_b_p, sw_b_n}
        logic [3:0] req;
    } vec_t;

    localparam int NV = 26;
    // times are negedge counts after reset release; periods start at edges 1, 21, 41 ...
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b0,4'd5,4'd0,1'b0,1'b0,8'd1, 4'b1000,4'd1}, // R1  t1  first turn-on
        '{1'b1,1'b0,1'b0,4'd5,4'd0,1'b1,1'b0,8'd3, 4'b1000,4'd3}, // R3  t4  trip inside hold
        '{1'b1,1'b0,1'b0,4'd5,4'd0,1'b1,1'b0,8'd1, 4'b0000,4'd2}, // R2  t5  cut after hold
        '{1'b1,1'b0,1'b0,4'd5,4'd0,1'b0,1'b0,8'd15,4'b0000,4'd2}, // R2  t20 stays off
        '{1'b1,1'b0,1'b0,4'd5,4'd0,1'b0,1'b0,8'd1, 4'b1000,4'd1}, // R1  t21 next period
        '{1'b1,1'b0,1'b0,4'd5,4'd0,1'b0,1'b0,8'd9, 4'b1000,4'd1}, // R1  t30
        '{1'b1,1'b0,1'b0,4'd5,4'd0,1'b1,1'b0,8'd2, 4'b1000,4'd2}, // R2  t32 sync latency
        '{1'b1,1'b0,1'b0,4'd5,4'd0,1'b1,1'b0,8'd1, 4'b0000,4'd2}, // R2  t33 third edge
        '{1'b1,1'b0,1'b0,4'd5,4'd0,1'b0,1'b0,8'd8, 4'b1000,4'd1}, // R1  t41
        '{1'b1,1'b0,1'b0,4'd5,4'd3,1'b0,1'b0,8'd19,4'b1000,4'd1}, // R1  t60 B waits
        '{1'b1,1'b0,1'b0,4'd5,4'd3,1'b0,1'b0,8'd1, 4'b1010,4'd1}, // R1  t61 B on
        '{1'b1,1'b1,1'b0,4'd5,4'd3,1'b0,1'b0,8'd1, 4'b0010,4'd4}, // R4  t62 dead starts
        '{1'b1,1'b1,1'b0,4'd5,4'd3,1'b0,1'b0,8'd5, 4'b0010,4'd4}, // R4  t67 still dead
        '{1'b1,1'b1,1'b0,4'd5,4'd3,1'b0,1'b0,8'd1, 4'b0110,4'd4}, // R4  t68 complementary on
        '{1'b1,1'b1,1'b0,4'd0,4'd3,1'b0,1'b0,8'd1, 4'b0010,4'd5}, // R5  t69 level zero
        '{1'b1,1'b1,1'b0,4'd7,4'd3,1'b0,1'b0,8'd11,4'b0010,4'd5}, // R5  t80 waits for period
        '{1'b1,1'b1,1'b0,4'd7,4'd3,1'b0,1'b0,8'd1, 4'b0110,4'd5}, // R5  t81
        '{1'b0,1'b1,1'b1,4'd7,4'd3,1'b0,1'b0,8'd10,4'b0000,4'd6}, // R6  t91 blanked, side ignored
        '{1'b1,1'b1,1'b0,4'd7,4'd3,1'b0,1'b0,8'd1, 4'b0110,4'd6}, // R6  t92 resumes
        '{1'b1,1'b1,1'b0,4'd7,4'd3,1'b1,1'b1,8'd3, 4'b0000,4'd2}, // R2  t95 both cut
        '{1'b1,1'b1,1'b0,4'd7,4'd3,1'b0,1'b0,8'd6, 4'b0000,4'd6}, // R6  t101 oscillator was frozen
        '{1'b1,1'b1,1'b0,4'd7,4'd3,1'b0,1'b0,8'd9, 4'b0000,4'd6}, // R6  t110
        '{1'b1,1'b1,1'b0,4'd7,4'd3,1'b0,1'b0,8'd1, 4'b0110,4'd1}, // R1  t111 shifted start
        '{1'b1,1'b1,1'b1,4'd7,4'd3,1'b0,1'b0,8'd1, 4'b0100,4'd4}, // R4  t112 B dead
        '{1'b1,1'b1,1'b1,4'd7,4'd3,1'b0,1'b0,8'd5, 4'b0100,4'd4}, // R4  t117
        '{1'b1,1'b1,1'b1,4'd7,4'd3,1'b0,1'b0,8'd1, 4'b0101,4'd8}  // R8  t118 pol 1 -> sw_b_n
    };

    function automatic logic [3:0] outs();
        return {sw_a_p, sw_a_n, sw_b_p, sw_b_n};
    endfunction

    task automatic check(input logic [3:0] exp, input int req, input string what);
        n_chk++;
        if (outs() !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %b expected %b", req, what, outs(), exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R7: reset state while reset held with drive enabled
        step(3);
        check(4'b0000, 7, "outputs during reset");

        for (int v = 0; v < NV; v++) begin
            drive_en = VECS[v].en;
            pol_a    = VECS[v].pa;
            pol_b    = VECS[v].pb;
            lvl_a    = VECS[v].la;
            lvl_b    = VECS[v].lb;
            trip_a   = VECS[v].ta;
            trip_b   = VECS[v].tb;
            if (v == 0) rst_n = 1'b1;
            step(int'(VECS[v].wt));
            check(VECS[v].exp, int'(VECS[v].req), $sformatf("vector %0d", v));
        end

        // R7: reset cancels a pending dead interval and restores primary sides
        pol_a = 1'b0;
        step(1);
        check(4'b0001, 4, "A dead begins");
        rst_n = 1'b0;
        step(2);
        check(4'b0000, 7, "reset mid dead");
        pol_b = 1'b0;
        rst_n = 1'b1;
        step(1);
        check(4'b1010, 7, "restart without dead");
        step(19);
        check(4'b1010, 7, "oscillator restarted at zero");

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (200000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule